// File: doc/BRIEF.md
# Link Interrupt Pending Controller

This block gathers interrupt events for a chip-to-chip serial link peripheral and presents them to the host as one level-sensitive user interrupt. Events come from two sources. Interrupt packets from the far end of the link carry a 32-bit status word, which can be merged straight into the pending bits. The local link logic raises status events, which are posted on one vector bit that software chooses. Software reads a priority register to find the most urgent pending vector and acknowledges it by writing that index back. It can also clear any group of bits through a write-one-to-clear status register.

The same register file also sends events the other way. When software writes a 6-bit vector to the soft-event register, the block raises a request toward the link packet transmitter. The request and its vector stay steady until the transmitter accepts them. Link framing, serialisation and routing of the interrupt to a particular core are outside this block.

Register word addresses (`bus_addr_i`):
- 0: control.
- 1: pending status, write-one-to-clear.
- 2: priority vector, with write-to-acknowledge.
- 3: soft-event generate. Reads return zero.

Top module: `lnk_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the following hold:
  - All pending bits are zero and the control register reads zero.
  - `irq_o` is low and `tx_req_o` is low.
  - The priority register reads 0x3F.
- R2: When control bit 0 (direct mode) is set, a cycle with `pkt_valid_i` high ORs `pkt_status_i` into the pending bits. When direct mode is clear, the packet leaves the pending bits unchanged.
- R3: When control bit 1 (local enable) is set, a cycle with `stat_evt_i` high sets the pending bit whose index is in control bits 12:8. When local enable is clear, the event leaves the pending bits unchanged.
- R4: Writing address 1 clears every pending bit whose write-data bit is 1. Bits written as 0 keep their value, and reading address 1 returns the pending bits.
- R5: If a bit is set by a packet or a local event in the same cycle that a write clears it, the bit ends up set.
- R6: Reading address 2 returns, in bits 5:0, the index of the lowest-numbered pending bit (bit 0 has the highest priority), with all other bits zero. When nothing is pending it returns 0x3F.
- R7: Writing address 2 clears only the pending bit whose index is given in write-data bits 4:0.
- R8: `irq_o` is high exactly when at least one pending bit is set. After a write clears the last pending bit, `irq_o` is low from the next clock edge.
- R9: When no request is outstanding, writing address 3 raises `tx_req_o` after the write edge, with `tx_vec_o` equal to write-data bits 5:0. Both hold until a cycle with `tx_ack_i` high, after which `tx_req_o` is low.
- R10: A write to address 3 while `tx_req_o` is high is ignored: `tx_vec_o` keeps its value.
- R11: The control register reads back as follows, with all other bits zero:
  - bit 0: direct mode.
  - bit 1: local enable.
  - bits 12:8: local vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| pkt_valid_i | input | 1 | Received interrupt packet valid |
| pkt_status_i | input | 32 | Status word of the received packet |
| stat_evt_i | input | 1 | Local link status event pulse |
| irq_o | output | 1 | Aggregated user interrupt to the host |
| tx_req_o | output | 1 | Outgoing soft-event request |
| tx_vec_o | output | 6 | Vector carried by the outgoing request |
| tx_ack_i | input | 1 | Transmitter accepts the request |

## Verification
The bench drives a packet together with a clear of the same bit in one cycle. A design that let the clear win would lose the event and read the bit back as zero. Priority readback is checked with pending sets whose lowest bit is 4, 5 and 31, and with an empty set. A reversed encoder, or a missing "none" code, would report a wrong index instead of 0x3F. The bench watches `irq_o` on both sides of the edge that clears the last bit, which catches a design with an extra register stage or an early drop. It also writes the soft-event register while a request is outstanding, so a design that overwrote the vector, or dropped the request before the acknowledge, would send the wrong event to the far side.

// File: rtl/lnk_irq_pkg.sv
package lnk_irq_pkg;

    // Number of interrupt vectors held in the pending register.
    localparam int NUM_VEC   = 32;
    localparam int VEC_W     = $clog2(NUM_VEC);
    // Width of the reported and transmitted vector field.
    localparam int SOFT_W    = 6;
    localparam int ADDR_W    = 2;
    // Bit position of the local vector field in the control word.
    localparam int CTRL_VLSB = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_PEND = 2'd1,
        REG_PRIO = 2'd2,
        REG_SOFT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [VEC_W-1:0] local_vec;
        logic             local_en;
        logic             direct_en;
    } ctrl_t;

    typedef struct packed {
        logic              valid;
        logic [SOFT_W-1:0] vec;
    } soft_req_t;

    localparam logic [SOFT_W-1:0] VEC_NONE = '1;

    function automatic logic [NUM_VEC-1:0] vec_to_mask(input logic [VEC_W-1:0] idx);
        logic [NUM_VEC-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/lnk_irq_regs.sv
module lnk_irq_regs
    import lnk_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [NUM_VEC-1:0] bus_wdata_i,
    output logic [NUM_VEC-1:0] bus_rdata_o,
    input  logic [NUM_VEC-1:0] pend_i,
    input  logic [SOFT_W-1:0]  prio_vec_i,
    output ctrl_t              ctrl_o,
    output logic [NUM_VEC-1:0] clr_mask_o,
    output logic               soft_wr_o,
    output logic [SOFT_W-1:0]  soft_vec_o
);

    logic  wr_en;
    ctrl_t ctrl_q;

    assign wr_en = bus_sel_i && bus_we_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && bus_addr_i == REG_CTRL) begin
            ctrl_q.direct_en <= bus_wdata_i[0];
            ctrl_q.local_en  <= bus_wdata_i[1];
            ctrl_q.local_vec <= bus_wdata_i[CTRL_VLSB +: VEC_W];
        end
    end

    assign ctrl_o = ctrl_q;

    // Clear requests from the status register and from the acknowledge path.
    always_comb begin
        clr_mask_o = '0;
        if (wr_en && bus_addr_i == REG_PEND) begin
            clr_mask_o = bus_wdata_i;
        end else if (wr_en && bus_addr_i == REG_PRIO) begin
            clr_mask_o = vec_to_mask(bus_wdata_i[VEC_W-1:0]);
        end
    end

    assign soft_wr_o  = wr_en && bus_addr_i == REG_SOFT;
    assign soft_vec_o = bus_wdata_i[SOFT_W-1:0];

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            REG_CTRL: begin
                bus_rdata_o[0] = ctrl_q.direct_en;
                bus_rdata_o[1] = ctrl_q.local_en;
                bus_rdata_o[CTRL_VLSB +: VEC_W] = ctrl_q.local_vec;
            end
            REG_PEND: bus_rdata_o = pend_i;
            REG_PRIO: bus_rdata_o[SOFT_W-1:0] = prio_vec_i;
            default:  bus_rdata_o = '0;
        endcase
    end

    // R7: an acknowledge write must request exactly one clear
    p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr_i == REG_PRIO) |-> $countones(clr_mask_o) == 1);

endmodule

// File: rtl/lnk_irq_pend.sv
module lnk_irq_pend
    import lnk_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl_i,
    input  logic               pkt_valid_i,
    input  logic [NUM_VEC-1:0] pkt_status_i,
    input  logic               stat_evt_i,
    input  logic [NUM_VEC-1:0] clr_mask_i,
    output logic [NUM_VEC-1:0] pend_o
);

    logic [NUM_VEC-1:0] pkt_mask;
    logic [NUM_VEC-1:0] loc_mask;
    logic [NUM_VEC-1:0] set_mask;
    logic [NUM_VEC-1:0] pend_q;

    assign pkt_mask = (pkt_valid_i && ctrl_i.direct_en) ? pkt_status_i : '0;
    assign loc_mask = (stat_evt_i && ctrl_i.local_en)
                      ? vec_to_mask(ctrl_i.local_vec) : '0;
    assign set_mask = pkt_mask | loc_mask;

    // Per-bit update: a set in the same cycle overrides a clear.
    for (genvar k = 0; k < NUM_VEC; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[k] <= 1'b0;
            end else if (set_mask[k]) begin
                pend_q[k] <= 1'b1;
            end else if (clr_mask_i[k]) begin
                pend_q[k] <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;

    // R5: a bit both set and cleared in one cycle must remain set
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (set_mask & clr_mask_i) != '0 |=>
        (pend_q & $past(set_mask & clr_mask_i)) == $past(set_mask & clr_mask_i));

    // R4: cleared bits without a competing set must be zero afterwards
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_mask_i & ~set_mask) != '0 |=>
        (pend_q & $past(clr_mask_i & ~set_mask)) == '0);

    // R2/R3: no pending bit appears without a set source
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        set_mask == '0 |=> (pend_q & ~$past(pend_q)) == '0);

endmodule

// File: rtl/lnk_irq_prio.sv
module lnk_irq_prio
    import lnk_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] pend_i,
    output logic [SOFT_W-1:0]  vec_o
);

    // Scan from the lowest-priority bit down so bit 0 has the last word.
    always_comb begin
        vec_o = VEC_NONE;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                vec_o = SOFT_W'(i);
            end
        end
    end

    // R6: reported vector is pending and no lower index is pending
    p_prio_lowest_r6: assert property (@(posedge clk) disable iff (rst)
        pend_i != '0 |->
        pend_i[vec_o[VEC_W-1:0]] &&
        (pend_i & (vec_to_mask(vec_o[VEC_W-1:0]) - 1'b1)) == '0);

    // R6: the none code only when nothing is pending
    p_prio_none_r6: assert property (@(posedge clk) disable iff (rst)
        (vec_o == VEC_NONE) |-> pend_i == '0);

endmodule

// File: rtl/lnk_irq_softtx.sv
module lnk_irq_softtx
    import lnk_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_wr_i,
    input  logic [SOFT_W-1:0] soft_vec_i,
    input  logic              tx_ack_i,
    output logic              tx_req_o,
    output logic [SOFT_W-1:0] tx_vec_o
);

    soft_req_t req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (req_q.valid) begin
            if (tx_ack_i) begin
                req_q.valid <= 1'b0;
            end
        end else if (soft_wr_i) begin
            req_q.valid <= 1'b1;
            req_q.vec   <= soft_vec_i;
        end
    end

    assign tx_req_o = req_q.valid;
    assign tx_vec_o = req_q.vec;

    // R9/R10: an unaccepted request holds with a stable vector
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        tx_req_o && !tx_ack_i |=> tx_req_o && $stable(tx_vec_o));

    // R9: an accepted request drops on the following edge
    p_ack_drop_r9: assert property (@(posedge clk) disable iff (rst)
        tx_req_o && tx_ack_i |=> !tx_req_o);

endmodule

// File: rtl/lnk_irq_ctrl.sv
module lnk_irq_ctrl
    import lnk_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic              pkt_valid_i,
    input  logic [31:0]       pkt_status_i,
    input  logic              stat_evt_i,
    output logic              irq_o,
    output logic              tx_req_o,
    output logic [5:0]        tx_vec_o,
    input  logic              tx_ack_i
);

    ctrl_t              ctrl;
    logic [NUM_VEC-1:0] clr_mask;
    logic [NUM_VEC-1:0] pend;
    logic [SOFT_W-1:0]  prio_vec;
    logic               soft_wr;
    logic [SOFT_W-1:0]  soft_vec;

    lnk_irq_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_sel_i   (bus_sel_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .pend_i      (pend),
        .prio_vec_i  (prio_vec),
        .ctrl_o      (ctrl),
        .clr_mask_o  (clr_mask),
        .soft_wr_o   (soft_wr),
        .soft_vec_o  (soft_vec)
    );

    lnk_irq_pend u_pend (
        .clk          (clk),
        .rst          (rst),
        .ctrl_i       (ctrl),
        .pkt_valid_i  (pkt_valid_i),
        .pkt_status_i (pkt_status_i),
        .stat_evt_i   (stat_evt_i),
        .clr_mask_i   (clr_mask),
        .pend_o       (pend)
    );

    lnk_irq_prio u_prio (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend),
        .vec_o  (prio_vec)
    );

    lnk_irq_softtx u_soft (
        .clk        (clk),
        .rst        (rst),
        .soft_wr_i  (soft_wr),
        .soft_vec_i (soft_vec),
        .tx_ack_i   (tx_ack_i),
        .tx_req_o   (tx_req_o),
        .tx_vec_o   (tx_vec_o)
    );

    assign irq_o = |pend;

    // R8: the interrupt only rises after an incoming event
    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(pkt_valid_i || stat_evt_i));

    // R8: the interrupt only falls after a register write
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(bus_sel_i && bus_we_i));

endmodule

// File: tb/tb_lnk_irq_ctrl.sv
module tb_lnk_irq_ctrl;

    localparam int OP_WR  = 0;
    localparam int OP_RD  = 1;
    localparam int OP_PKT = 2;
    localparam int OP_EVT = 3;
    localparam int OP_IRQ = 4;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 26;
    localparam step_t TBL [NSTEP] = '{
        '{3'd1, 2'd0, 32'h0,          32'h0,          4'd11}, // R11 reset ctrl
        '{3'd0, 2'd0, 32'h0000_0503,  32'h0,          4'd11},
        '{3'd1, 2'd0, 32'h0,          32'h0000_0503,  4'd11}, // R11 readback
        '{3'd2, 2'd0, 32'h8000_0010,  32'h0,          4'd2},
        '{3'd1, 2'd1, 32'h0,          32'h8000_0010,  4'd2},  // R2 direct merge
        '{3'd1, 2'd2, 32'h0,          32'h0000_0004,  4'd6},  // R6
        '{3'd4, 2'd0, 32'h0,          32'h1,          4'd8},  // R8
        '{3'd3, 2'd0, 32'h0,          32'h0,          4'd3},
        '{3'd1, 2'd1, 32'h0,          32'h8000_0030,  4'd3},  // R3 local vec 5
        '{3'd0, 2'd1, 32'h0000_0010,  32'h0,          4'd4},
        '{3'd1, 2'd1, 32'h0,          32'h8000_0020,  4'd4},  // R4 w1c
        '{3'd1, 2'd2, 32'h0,          32'h0000_0005,  4'd6},  // R6
        '{3'd0, 2'd2, 32'h0000_0005,  32'h0,          4'd7},
        '{3'd1, 2'd1, 32'h0,          32'h8000_0000,  4'd7},  // R7 ack
        '{3'd1, 2'd2, 32'h0,          32'h0000_001F,  4'd6},  // R6 bit 31
        '{3'd0, 2'd0, 32'h0000_0200,  32'h0,          4'd11},
        '{3'd2, 2'd0, 32'h0000_0001,  32'h0,          4'd2},
        '{3'd3, 2'd0, 32'h0,          32'h0,          4'd3},
        '{3'd1, 2'd1, 32'h0,          32'h8000_0000,  4'd2},  // R2 R3 ignored
        '{3'd0, 2'd1, 32'h0,          32'h0,          4'd4},
        '{3'd1, 2'd1, 32'h0,          32'h8000_0000,  4'd4},  // R4 zero write
        '{3'd0, 2'd2, 32'h0000_001F,  32'h0,          4'd7},
        '{3'd1, 2'd1, 32'h0,          32'h0,          4'd7},  // R7
        '{3'd1, 2'd2, 32'h0,          32'h0000_003F,  4'd6},  // R6 none
        '{3'd4, 2'd0, 32'h0,          32'h0,          4'd8},  // R8 low
        '{3'd1, 2'd0, 32'h0,          32'h0000_0200,  4'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel_i, bus_we_i;
    logic [1:0]  bus_addr_i;
    logic [31:0] bus_wdata_i, bus_rdata_o;
    logic        pkt_valid_i;
    logic [31:0] pkt_status_i;
    logic        stat_evt_i;
    logic        irq_o, tx_req_o, tx_ack_i;
    logic [5:0]  tx_vec_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    lnk_irq_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .bus_sel_i    (bus_sel_i),
        .bus_we_i     (bus_we_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .bus_rdata_o  (bus_rdata_o),
        .pkt_valid_i  (pkt_valid_i),
        .pkt_status_i (pkt_status_i),
        .stat_evt_i   (stat_evt_i),
        .irq_o        (irq_o),
        .tx_req_o     (tx_req_o),
        .tx_vec_o     (tx_vec_o),
        .tx_ack_i     (tx_ack_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_we_i = 1'b0;
    endtask

    task automatic bus_read(input string req, input logic [1:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr_i = a; bus_sel_i = 1'b1; bus_we_i = 1'b0;
        #1 check(req, bus_rdata_o, exp);
        bus_sel_i = 1'b0;
    endtask

    task automatic send_pkt(input logic [31:0] s);
        @(negedge clk);
        pkt_valid_i = 1'b1; pkt_status_i = s;
        @(negedge clk);
        pkt_valid_i = 1'b0;
    endtask

    task automatic send_evt();
        @(negedge clk);
        stat_evt_i = 1'b1;
        @(negedge clk);
        stat_evt_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        bus_sel_i = 1'b0; bus_we_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
        pkt_valid_i = 1'b0; pkt_status_i = '0; stat_evt_i = 1'b0; tx_ack_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #1;
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 tx_req", {31'b0, tx_req_o}, 32'h0);
        bus_read("R1 pend", 2'd1, 32'h0);
        bus_read("R1 prio", 2'd2, 32'h3F);

        // Table walk
        for (int i = 0; i < NSTEP; i++) begin
            case (int'(TBL[i].op))
                OP_WR:  bus_write(TBL[i].addr, TBL[i].data);
                OP_PKT: send_pkt(TBL[i].data);
                OP_EVT: send_evt();
                OP_RD:  bus_read($sformatf("R%0d step %0d", TBL[i].req, i),
                                 TBL[i].addr, TBL[i].exp);
                default: begin
                    @(negedge clk);
                    #1 check($sformatf("R%0d irq step %0d", TBL[i].req, i),
                             {31'b0, irq_o}, TBL[i].exp);
                end
            endcase
        end

        // R5: packet sets bit 0 while a write clears bits 1:0
        bus_write(2'd0, 32'h1);
        send_pkt(32'h3);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 2'd1; bus_wdata_i = 32'h3;
        pkt_valid_i = 1'b1; pkt_status_i = 32'h1;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_we_i = 1'b0; pkt_valid_i = 1'b0;
        bus_read("R5 set wins", 2'd1, 32'h1);

        // R8: drop timing around the last clear
        @(negedge clk);
        bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 2'd1; bus_wdata_i = 32'h1;
        #1 check("R8 before edge", {31'b0, irq_o}, 32'h1);
        @(posedge clk);
        #1 check("R8 after edge", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        bus_sel_i = 1'b0; bus_we_i = 1'b0;

        // R9: soft event request
        bus_write(2'd3, 32'h0000_002A);
        #1;
        check("R9 req", {31'b0, tx_req_o}, 32'h1);
        check("R9 vec", {26'b0, tx_vec_o}, 32'h2A);
        // R10: write while busy ignored
        bus_write(2'd3, 32'h0000_0015);
        repeat (2) @(negedge clk);
        #1;
        check("R10 vec held", {26'b0, tx_vec_o}, 32'h2A);
        check("R9 req held", {31'b0, tx_req_o}, 32'h1);
        @(negedge clk);
        tx_ack_i = 1'b1;
        @(negedge clk);
        tx_ack_i = 1'b0;
        #1 check("R9 req dropped", {31'b0, tx_req_o}, 32'h0);
        bus_write(2'd3, 32'h0000_0007);
        #1;
        check("R9 second req", {31'b0, tx_req_o}, 32'h1);
        check("R9 second vec", {26'b0, tx_vec_o}, 32'h07);
        @(negedge clk);
        tx_ack_i = 1'b1;
        @(negedge clk);
        tx_ack_i = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule